// File: doc/BRIEF.md
# Table-driven programmable state machine

This block is a finite state machine whose whole transition function sits in a small writable table, not in gates. On each clock edge, the current state and a few external input bits together select one table entry. That entry supplies the next state and a group of output bits, and both are captured into registers at that edge. Loading new contents into the table changes what the machine does without any change to its structure.

Table contents arrive through a program-write port that updates one entry per cycle. A run-enable input controls whether the machine advances. A typical use is to hold run-enable low, write every entry, and then raise run-enable. The table can later be rewritten while the machine is stopped or while it is running.

Top module: `tfsm_top`

## Requirements
- R1: While `rst_n` is low, `cur_state` and `cur_out` are 0. Reset is asynchronous and active low.
- R2: When `run_en` is high at a rising edge, `cur_state` takes bits [7:4] of the table entry whose index is `{cur_state, ext_in}`. The state occupies index bits [5:2] and `ext_in` occupies index bits [1:0].
- R3: At that same edge, `cur_out` takes bits [3:0] of that same entry.
- R4: When `run_en` is low at a rising edge, `cur_state` and `cur_out` keep their values, whatever `ext_in` or the program port carry.
- R5: When `prog_we` is high at a rising edge, the entry at `prog_addr` is replaced by `prog_data`. The port writes one entry per cycle, whether `run_en` is high or low. The first transition that reads the entry afterwards uses the new contents.
- R6: If a write hits the entry being read in the same cycle, that cycle's transition uses the old contents. The new contents apply from the following cycle on.
- R7: Loading a second table, without any reset, makes the machine follow the new table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | High: advance one transition per cycle. Low: hold. |
| ext_in | input | 2 | External input bits; the low part of the table index |
| prog_we | input | 1 | Write enable for the table |
| prog_addr | input | 6 | Index of the entry to write |
| prog_data | input | 8 | New entry: next state in [7:4], outputs in [3:0] |
| cur_state | output | 4 | Registered current state |
| cur_out | output | 4 | Registered output bits |

## Verification
The assertions assume that no entry is read during a running cycle before it has been written at least once. The table has no reset value, so an unwritten entry would carry unknown values into the state register. The bench keeps `run_en` low and fills all 64 entries before the first running cycle, and it does the same before it switches to the second table. It drives every input to a known value on every cycle, which keeps the hold and write properties free of unknowns.

// File: rtl/tfsm_pkg.sv
`timescale 1ns/1ps
package tfsm_pkg;
   // default geometry of the machine
   localparam int TFSM_ST_W    = 4;
   localparam int TFSM_IN_W    = 2;
   localparam int TFSM_OUT_W   = 4;
   // largest table index width accepted at elaboration
   localparam int TFSM_MAX_AW  = 12;
endpackage

// File: rtl/tfsm_index.sv
`timescale 1ns/1ps
// Forms the table index from the state and the external inputs.
module tfsm_index #(
   parameter int ST_W   = 4,
   parameter int IN_W   = 2,
   parameter bit IN_LSB = 1'b1,
   localparam int AW    = ST_W + IN_W
) (
   input  logic [ST_W-1:0] st,
   input  logic [IN_W-1:0] ins,
   output logic [AW-1:0]   idx
);
   generate
      if (IN_LSB) begin : g_in_low
         assign idx = {st, ins};
      end else begin : g_in_high
         assign idx = {ins, st};
      end
   endgenerate
endmodule

// File: rtl/tfsm_table.sv
`timescale 1ns/1ps
// Writable transition table: one synchronous write port, one combinational read port.
module tfsm_table #(
   parameter int AW = 6,
   parameter int WW = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [WW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [WW-1:0] rd_word
);
   logic [WW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         cells[wr_addr] <= wr_data;
      end
   end

   // read sees the contents before this cycle's write (no bypass)
   assign rd_word = cells[rd_addr];

   // R5: a written entry holds the written word after the edge
   p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cells[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/tfsm_core_reg.sv
`timescale 1ns/1ps
// State and output registers, advanced only while run is enabled.
module tfsm_core_reg #(
   parameter int ST_W  = 4,
   parameter int OUT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [ST_W-1:0]  nxt_st,
   input  logic [OUT_W-1:0] nxt_out,
   output logic [ST_W-1:0]  cur_st,
   output logic [OUT_W-1:0] cur_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_st  <= '0;
         cur_out <= '0;
      end else if (run_en) begin
         cur_st  <= nxt_st;
         cur_out <= nxt_out;
      end
   end

   // R1: leaving reset, both registers are clear
   p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cur_st == '0 && cur_out == '0));

   // R4: a stopped machine keeps state and outputs
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> ($stable(cur_st) && $stable(cur_out)));
endmodule

// File: rtl/tfsm_top.sv
`timescale 1ns/1ps
module tfsm_top #(
   parameter int ST_W   = tfsm_pkg::TFSM_ST_W,
   parameter int IN_W   = tfsm_pkg::TFSM_IN_W,
   parameter int OUT_W  = tfsm_pkg::TFSM_OUT_W,
   parameter bit IN_LSB = 1'b1,
   localparam int AW    = ST_W + IN_W,
   localparam int WW    = ST_W + OUT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [IN_W-1:0]  ext_in,
   input  logic             prog_we,
   input  logic [AW-1:0]    prog_addr,
   input  logic [WW-1:0]    prog_data,
   output logic [ST_W-1:0]  cur_state,
   output logic [OUT_W-1:0] cur_out
);
   // elaboration-time parameter checks
   generate
      if (ST_W < 1 || IN_W < 1 || OUT_W < 1) begin : g_bad_width
         $error("tfsm_top: every width must be at least 1");
      end
      if (AW > tfsm_pkg::TFSM_MAX_AW) begin : g_bad_depth
         $error("tfsm_top: table index too wide");
      end
   endgenerate

   logic [AW-1:0] rd_idx;
   logic [WW-1:0] rd_word;

   tfsm_index #(.ST_W(ST_W), .IN_W(IN_W), .IN_LSB(IN_LSB)) u_index (
      .st  (cur_state),
      .ins (ext_in),
      .idx (rd_idx)
   );

   tfsm_table #(.AW(AW), .WW(WW)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (prog_we),
      .wr_addr (prog_addr),
      .wr_data (prog_data),
      .rd_addr (rd_idx),
      .rd_word (rd_word)
   );

   tfsm_core_reg #(.ST_W(ST_W), .OUT_W(OUT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .nxt_st  (rd_word[WW-1:OUT_W]),
      .nxt_out (rd_word[OUT_W-1:0]),
      .cur_st  (cur_state),
      .cur_out (cur_out)
   );

   // R2 / R6: the state follows the word read before any same-cycle write
   p_next_from_old_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> cur_state == $past(rd_word[WW-1:OUT_W]));

   // R3: outputs come from the same entry as the state
   p_out_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> cur_out == $past(rd_word[OUT_W-1:0]));
endmodule

// File: tb/sim_tfsm_top.sv
`timescale 1ns/1ps
module sim_tfsm_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0;
   logic [1:0] ext_in = '0;
   logic       prog_we = 1'b0;
   logic [5:0] prog_addr = '0;
   logic [7:0] prog_data = '0;
   logic [3:0] cur_state;
   logic [3:0] cur_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] model [64];
   logic [3:0] exp_st;
   logic [3:0] exp_o;

   always #5 clk = ~clk;

   tfsm_top u0 (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .ext_in(ext_in),
      .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
      .cur_state(cur_state), .cur_out(cur_out)
   );

   function automatic logic [7:0] table_a(input int a);
      int s = a / 4;
      int i = a % 4;
      logic [3:0] n = 4'((s * 5 + i * 3 + 1) % 16);
      logic [3:0] o = 4'(s) ^ {2'(i), 2'(i)};
      return {n, o};
   endfunction

   function automatic logic [7:0] table_b(input int a);
      int s = a / 4;
      int i = a % 4;
      logic [3:0] n = 4'(((15 - s) + i * 7) % 16);
      logic [3:0] o = 4'((s * 3 + i) % 16);
      return {n, o};
   endfunction

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle, entered and left at a falling edge
   task automatic cyc(input bit run, input logic [1:0] in, input bit we,
                      input logic [5:0] addr, input logic [7:0] data,
                      input string tag_s, input string tag_o);
      int idx;
      run_en = run; ext_in = in; prog_we = we; prog_addr = addr; prog_data = data;
      idx = int'({exp_st, in});
      if (run) begin
         exp_st = model[idx][7:4];
         exp_o  = model[idx][3:0];
      end
      if (we) model[addr] = data;
      @(negedge clk);
      check(tag_s, cur_state, exp_st);
      check(tag_o, cur_out, exp_o);
   endtask

   task automatic load(input bit use_b, input string tag);
      for (int a = 0; a < 64; a++) begin
         cyc(1'b0, 2'(a * 3), 1'b1, 6'(a), use_b ? table_b(a) : table_a(a), tag, tag);
      end
      prog_we = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      exp_st = '0; exp_o = '0;
      repeat (3) @(negedge clk);
      check("R1 reset state", cur_state, 4'h0);
      check("R1 reset out", cur_out, 4'h0);
      rst_n = 1'b1;

      // R4/R5: table fill while stopped, state stays 0
      load(1'b0, "R4");

      // R2/R3: walk the first table
      for (int k = 0; k < 256; k++) begin
         cyc(1'b1, 2'((k ^ (k >> 2) ^ (k >> 5)) & 3), 1'b0, '0, '0, "R2", "R3");
      end

      // R4: stopped, inputs and program port wiggle on an unrelated entry
      for (int k = 0; k < 20; k++) begin
         cyc(1'b0, 2'(k), 1'b0, 6'(k), 8'hFF, "R4", "R4");
      end

      // R5: write a self-loop into the current entry while stopped, then run
      cyc(1'b0, 2'd2, 1'b1, {exp_st, 2'd2}, {exp_st, 4'hC}, "R5", "R5");
      cyc(1'b1, 2'd2, 1'b0, '0, '0, "R5", "R5");

      // R6: overwrite the entry being read; old word this cycle, new next
      cyc(1'b1, 2'd2, 1'b1, {exp_st, 2'd2}, 8'h9D, "R6", "R6");
      cyc(1'b1, 2'd2, 1'b0, '0, '0, "R6", "R6");
      check("R6 new entry taken", cur_state, 4'h9);
      check("R6 new entry out", cur_out, 4'hD);

      // R7: reprogram with a second table, no reset
      load(1'b1, "R4");
      for (int k = 0; k < 256; k++) begin
         cyc(1'b1, 2'((k * 7 + (k >> 3)) & 3), 1'b0, '0, '0, "R7", "R7");
      end

      // R1: reset in the middle of a run
      rst_n = 1'b0;
      #1;
      check("R1 async reset state", cur_state, 4'h0);
      check("R1 async reset out", cur_out, 4'h0);
      @(negedge clk);
      check("R1 held state", cur_state, 4'h0);
      rst_n = 1'b1;
      exp_st = '0; exp_o = '0;
      cyc(1'b1, 2'd1, 1'b0, '0, '0, "R2", "R3");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule